// File: doc/BRIEF.md
# Pin Interrupt Sense Unit

This block watches the synchronized input pins of a general-purpose port and turns selected pin activity into interrupt requests. Each pin has its own settings. It can sense a level, either high or low. It can instead sense an edge: rising only, falling only, or both. The unit keeps a raw status bit for every pin and a masked view of that status. It drives one combined interrupt line to the interrupt controller.

Software reaches the unit over the same simple register bus as the port: single-cycle write strobes, and read strobes with registered read data. Edge events stay latched until software acknowledges them by writing ones to the acknowledge register. A level-sensed pin's status always tracks the pin. Register offsets are fixed so that existing drivers decode them unchanged.

Top module: `gpint_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every configuration register, every status bit, `irq_o` and `bus_rdata` are cleared to 0.
- R2: Four configuration registers can be written and read back. Offset 0x404 is sense mode: bit=1 selects level, bit=0 selects edge. Offset 0x408 is dual-edge. Offset 0x40C is polarity. Offset 0x410 is interrupt enable. A read with `bus_rd` high loads `bus_rdata` at the next clock edge, and `bus_rdata` holds while `bus_rd` is low. Offsets 0x414 and 0x418 are read-only. Reads of 0x41C and of unmapped offsets return 0. Writes to unmapped offsets change no register.
- R3: For a pin with sense=1, the raw status bit at each clock edge becomes pin when polarity=1, or NOT pin when polarity=0. Acknowledge writes do not affect it. The dual-edge bit has no effect in this mode.
- R4: For a pin with sense=0 and dual-edge=0, the raw bit is set by a rising edge when polarity=1 and by a falling edge when polarity=0. An edge means the pin value differs from its value one clock earlier. The opposite edge does not set the bit.
- R5: For a pin with sense=0 and dual-edge=1, any edge sets the raw bit, whatever the polarity bit holds.
- R6: An edge-mode raw bit stays set until a write to offset 0x41C carries a 1 in that bit position. Bits written as 0 leave status unchanged.
- R7: If an edge that would set a bit arrives in the same cycle as an acknowledge of that bit, the bit stays set.
- R8: Raw status reads at offset 0x414. Masked status reads at offset 0x418 and equals raw status AND enable.
- R9: `irq_o` is registered. In each cycle it equals the OR of (raw status AND enable) as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPIN | Synchronized pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | NPIN | Write data, one bit per pin |
| bus_rdata | output | NPIN | Registered read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with its default eight pins and twelve address bits. The full register window fits easily, and five sense modes fit within the eight pins. The bench rotates the five modes across the pins and runs each rotation with two enable masks. Each pin therefore sees every mode under many input transitions, mixed with acknowledge writes and status reads. Directed cycles cover reset, unmapped offsets, zero-bit acknowledges and the case where an acknowledge meets a new edge.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  localparam int OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [OFS_W-1:0] OFS_DUAL   = 12'h408;
  localparam logic [OFS_W-1:0] OFS_POL    = 12'h40C;
  localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h410;
  localparam logic [OFS_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [OFS_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [OFS_W-1:0] OFS_ACK    = 12'h41C;

  localparam int NCFG = 4;
  typedef enum logic [1:0] {
    CFG_SENSE  = 2'd0,
    CFG_DUAL   = 2'd1,
    CFG_POL    = 2'd2,
    CFG_ENABLE = 2'd3
  } cfg_idx_e;
endpackage

// File: rtl/gpint_cfg.sv
module gpint_cfg
  import gpint_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   sense_o,
  output logic [NPIN-1:0]   dual_o,
  output logic [NPIN-1:0]   pol_o,
  output logic [NPIN-1:0]   enable_o,
  output logic [NPIN-1:0]   ack_o
);
  localparam logic [ADDR_W-1:0] CFG_OFS [NCFG] = '{
    ADDR_W'(OFS_SENSE), ADDR_W'(OFS_DUAL), ADDR_W'(OFS_POL), ADDR_W'(OFS_ENABLE)
  };

  logic [NPIN-1:0] cfg_q [NCFG];

  for (genvar g = 0; g < NCFG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        cfg_q[g] <= '0;
      else if (wr_i && addr_i == CFG_OFS[g])
        cfg_q[g] <= wdata_i;
    end
  end

  assign sense_o  = cfg_q[CFG_SENSE];
  assign dual_o   = cfg_q[CFG_DUAL];
  assign pol_o    = cfg_q[CFG_POL];
  assign enable_o = cfg_q[CFG_ENABLE];

  // acknowledge is a strobe, not stored
  assign ack_o = (wr_i && addr_i == ADDR_W'(OFS_ACK)) ? wdata_i : '0;
endmodule

// File: rtl/gpint_detect.sv
module gpint_detect #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_i,
  input  logic [NPIN-1:0] sense_i,
  input  logic [NPIN-1:0] dual_i,
  input  logic [NPIN-1:0] pol_i,
  input  logic [NPIN-1:0] ack_i,
  output logic [NPIN-1:0] raw_o
);
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] raw_q;
  logic [NPIN-1:0] hit;

  // prev tracks the pin during reset so a pin already high is no edge
  always_ff @(posedge clk) prev_q <= pin_i;

  for (genvar k = 0; k < NPIN; k++) begin : g_pin
    logic rise, fall;
    assign rise   = pin_i[k] & ~prev_q[k];
    assign fall   = ~pin_i[k] & prev_q[k];
    assign hit[k] = dual_i[k] ? (rise | fall) : (pol_i[k] ? rise : fall);

    always_ff @(posedge clk) begin
      if (rst)
        raw_q[k] <= 1'b0;
      else if (sense_i[k])
        raw_q[k] <= ~(pin_i[k] ^ pol_i[k]);
      else
        raw_q[k] <= hit[k] | (raw_q[k] & ~ack_i[k]);
    end

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
      sense_i[k] |=> raw_q[k] == $past(pin_i[k] == pol_i[k])); // R3
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[k] && hit[k]) |=> raw_q[k]); // R7
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!sense_i[k] && !hit[k] && !ack_i[k]) |=> raw_q[k] == $past(raw_q[k])); // R6
  end

  assign raw_o = raw_q;
endmodule

// File: rtl/gpint_rdmux.sv
module gpint_rdmux
  import gpint_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   sense_i,
  input  logic [NPIN-1:0]   dual_i,
  input  logic [NPIN-1:0]   pol_i,
  input  logic [NPIN-1:0]   enable_i,
  input  logic [NPIN-1:0]   raw_i,
  output logic [NPIN-1:0]   rdata_o
);
  logic [NPIN-1:0] sel_d;
  logic [NPIN-1:0] rdata_q;

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_SENSE))  sel_d = sense_i;
    else if (addr_i == ADDR_W'(OFS_DUAL))   sel_d = dual_i;
    else if (addr_i == ADDR_W'(OFS_POL))    sel_d = pol_i;
    else if (addr_i == ADDR_W'(OFS_ENABLE)) sel_d = enable_i;
    else if (addr_i == ADDR_W'(OFS_RAW))    sel_d = raw_i;
    else if (addr_i == ADDR_W'(OFS_MASKED)) sel_d = raw_i & enable_i;
    else                                    sel_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= sel_d;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_i |=> $stable(rdata_q)); // R2

  assign rdata_o = rdata_q;
endmodule

// File: rtl/gpint_unit.sv
module gpint_unit #(
  parameter int NPIN   = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  output logic              irq_o
);
  logic [NPIN-1:0] sense, dual, pol, enable, ack, raw;
  logic            irq_q;

  gpint_cfg #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .sense_o(sense), .dual_o(dual), .pol_o(pol), .enable_o(enable), .ack_o(ack)
  );

  gpint_detect #(.NPIN(NPIN)) u_detect (
    .clk(clk), .rst(rst), .pin_i(pin_i), .sense_i(sense), .dual_i(dual),
    .pol_i(pol), .ack_i(ack), .raw_o(raw)
  );

  gpint_rdmux #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_rdmux (
    .clk(clk), .rst(rst), .rd_i(bus_rd), .addr_i(bus_addr), .sense_i(sense),
    .dual_i(dual), .pol_i(pol), .enable_i(enable), .raw_i(raw), .rdata_o(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(raw & enable);
  end

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> irq_q == $past(|(raw & enable))); // R9

  assign irq_o = irq_q;
endmodule

// File: tb/gpint_unit_tb.sv
module gpint_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int AW = 12;
  localparam logic [AW-1:0] A_SNS = 12'h404, A_DUA = 12'h408, A_POL = 12'h40C,
    A_ENA = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418, A_ACK = 12'h41C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] pin = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic irq_o;

  int total = 0;
  int bad = 0;

  logic [NP-1:0] m_sns, m_dua, m_pol, m_ena, m_raw, m_prev, m_rd;
  logic m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpint_unit #(.NPIN(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .pin_i(pin), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] model_read(input logic [AW-1:0] a);
    case (a)
      A_SNS: return m_sns;
      A_DUA: return m_dua;
      A_POL: return m_pol;
      A_ENA: return m_ena;
      A_RAW: return m_raw;
      A_MSK: return m_raw & m_ena;
      default: return '0;
    endcase
  endfunction

  // one bus cycle; model advances on the edge from values held before it
  task automatic cyc(input logic [NP-1:0] p, input logic w, input logic [AW-1:0] a,
                     input logic [NP-1:0] d, input logic r, input string tag);
    logic [NP-1:0] ack, nraw;
    logic nirq;
    @(negedge clk);
    pin = p; bus_wr = w; bus_addr = a; bus_wdata = d; bus_rd = r;
    @(posedge clk);
    nirq = |(m_raw & m_ena);
    if (r) m_rd = model_read(a);
    ack = (w && a == A_ACK) ? d : '0;
    for (int k = 0; k < NP; k++) begin
      logic rise, fall, hit;
      rise = p[k] & ~m_prev[k];
      fall = ~p[k] & m_prev[k];
      hit  = m_dua[k] ? (rise | fall) : (m_pol[k] ? rise : fall);
      if (m_sns[k]) nraw[k] = (p[k] == m_pol[k]);
      else          nraw[k] = hit | (m_raw[k] & ~ack[k]);
    end
    m_raw = nraw;
    m_prev = p;
    m_irq = nirq;
    if (w) begin
      if (a == A_SNS) m_sns = d;
      if (a == A_DUA) m_dua = d;
      if (a == A_POL) m_pol = d;
      if (a == A_ENA) m_ena = d;
    end
    #(CLK_PERIOD/4);
    check("R9 irq", {7'd0, irq_o}, {7'd0, m_irq});
    if (r) check(tag, bus_rdata, m_rd);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d, input string tag);
    cyc(m_prev, 1'b1, a, d, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(m_prev, 1'b0, a, '0, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_sns = '0; m_dua = '0; m_pol = '0; m_ena = '0; m_raw = '0; m_prev = '0; m_rd = '0; m_irq = 1'b0;
    pin = 8'hC3;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    m_prev = 8'hC3;
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 rdata", bus_rdata, '0);
    check("R1 irq", {7'd0, irq_o}, 8'd0);
    rd(A_SNS, "R1 sense"); rd(A_DUA, "R1 dual"); rd(A_POL, "R1 pol");
    rd(A_ENA, "R1 enable"); rd(A_RAW, "R1 raw"); rd(A_MSK, "R1 masked");

    // R2 readback and unmapped offsets
    wr(A_SNS, 8'h11, "R2"); wr(A_DUA, 8'h22, "R2"); wr(A_POL, 8'h44, "R2"); wr(A_ENA, 8'h88, "R2");
    rd(A_SNS, "R2 sense"); rd(A_DUA, "R2 dual"); rd(A_POL, "R2 pol"); rd(A_ENA, "R2 enable");
    wr(12'h420, 8'hFF, "R2"); wr(12'h004, 8'hFF, "R2"); wr(A_RAW, 8'hFF, "R2"); wr(A_MSK, 8'hFF, "R2");
    rd(A_SNS, "R2 unmapped no write"); rd(A_ENA, "R2 unmapped no write");
    rd(12'h420, "R2 unmapped read"); rd(A_ACK, "R2 ack reads zero");
    cyc(m_prev, 1'b0, A_SNS, '0, 1'b0, "R2 hold");
    check("R2 rdata held", bus_rdata, m_rd);

    // R7 and R6 directed on pin 0, rising edge mode
    wr(A_SNS, 8'h00, "R7"); wr(A_DUA, 8'h00, "R7"); wr(A_POL, 8'h01, "R7"); wr(A_ENA, 8'h01, "R7");
    cyc(8'h00, 1'b1, A_ACK, 8'hFF, 1'b0, "R6");
    cyc(8'h01, 1'b0, A_ACK, 8'h00, 1'b0, "R4");
    rd(A_RAW, "R4 rise sets");
    cyc(8'h00, 1'b1, A_ACK, 8'h00, 1'b0, "R6");
    rd(A_RAW, "R6 zero ack keeps");
    cyc(8'h01, 1'b1, A_ACK, 8'h01, 1'b0, "R7");
    rd(A_RAW, "R7 edge beats ack");
    check("R7 bit set", bus_rdata & 8'h01, 8'h01);
    wr(A_ACK, 8'h01, "R6");
    rd(A_RAW, "R6 ack clears");
    check("R6 bit clear", bus_rdata & 8'h01, 8'h00);

    // sweep: five modes rotated over pins, two enable masks
    for (int s = 0; s < 5; s++) begin
      for (int e = 0; e < 2; e++) begin
        logic [NP-1:0] vs, vd, vp;
        vs = '0; vd = '0; vp = '0;
        for (int k = 0; k < NP; k++) begin
          case ((k + s) % 5)
            0: begin vs[k] = 1'b1; vp[k] = 1'b1; vd[k] = s[0]; end
            1: begin vs[k] = 1'b1; vp[k] = 1'b0; end
            2: vp[k] = 1'b1;
            3: vp[k] = 1'b0;
            default: begin vd[k] = 1'b1; vp[k] = k[0]; end
          endcase
        end
        wr(A_SNS, vs, "R2"); wr(A_DUA, vd, "R5"); wr(A_POL, vp, "R2");
        wr(A_ENA, e == 0 ? 8'hFF : 8'h5A, "R8");
        wr(A_ACK, 8'hFF, "R6");
        for (int i = 0; i < 48; i++) begin
          logic [NP-1:0] p;
          p = 8'(i * 53 + s * 17) ^ 8'(i >> 1);
          case (i % 4)
            0: cyc(p, 1'b0, A_RAW, '0, 1'b1, "R3 R4 R5 raw");
            1: cyc(p, 1'b0, A_MSK, '0, 1'b1, "R8 masked");
            2: cyc(p, 1'b1, A_ACK, 8'(i * 91), 1'b0, "R6");
            default: cyc(p, 1'b1, A_ACK, 8'(i * 37), 1'b1, "R6 R3 ack read");
          endcase
        end
        rd(A_RAW, "R6 sticky raw"); rd(A_MSK, "R8 final masked");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule